// File: doc/BRIEF.md
# Two-Step Lookahead First-Order Recursive Filter

This block is a streaming fixed-point filter that computes the first-order recurrence y(k+1) = a·y(k) + b·u(k) on one channel of Q1.15 samples. The recursion is not built with a one-delay feedback loop. It is rewritten two steps ahead as y(k+1) = a²·y(k-1) + a·b·u(k-1) + b·u(k). The feedback path therefore runs through two registers, and the loop multiply-add gets two cycles instead of one. The iteration bound drops from (Tm+Ta) to (Tm+Ta)/2.

Software writes the coefficients a and b through a write strobe into a pending pair. The derived products a², a·b and the active b are captured from that pair only while reset is held, so a new coefficient set always starts from a cleared filter state. A sample presented with the input strobe leaves the block two cycles later as one rounded output word. Cycles without the strobe leave the filter state untouched.

Top module: `iir_la_top`

## Requirements
- R1: Sample k on `in_sample` produces the output y(k+1) = a²·y(k-1) + a·b·u(k-1) + b·u(k), which is the direct recurrence y(k+1) = a·y(k) + b·u(k) evaluated two steps ahead. When every product is exact, for example a = -1 (0x8000) with b = 1/2 (0x4000) and even inputs, the output equals the direct recurrence bit for bit.
- R2: Samples and coefficients are 16-bit two's-complement Q1.15 numbers, with value = word / 32768. The derived coefficients are held at full product precision in Q2.30, so a² = 1 is representable.
- R3: The three products are summed at full precision and rounded once to 16 bits. Rounding is to the nearest value, with ties going toward positive infinity, so +0.5 LSB becomes 1 and -0.5 LSB becomes 0.
- R4: Synchronous reset `rst` clears both feedback registers and the input delay register. The output sequence after reset therefore starts from y(0) = y(-1) = 0 and u(-1) = 0. During and just after reset, `out_valid` is 0 and `out_sample` is 0.
- R5: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, and at no other time. It is high for one cycle per sample.
- R6: Cycles with `in_valid` low do not advance the filter. The output sequence does not depend on idle gaps between samples, and `out_sample` holds its last value while `out_valid` is low.
- R7: A cycle with `coef_wr` high stores `coef_a` and `coef_b` as the pending coefficients. Outputs keep using the active set until at least one reset cycle after the write, and that reset loads the active set from the pending pair.
- R8: Samples may arrive on every cycle back to back. The output then emerges on every cycle.
- R9: Results outside the Q1.15 range wrap modulo 2^16. There is no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also loads the pending coefficients |
| coef_wr | input | 1 | Stores coef_a and coef_b as the pending coefficients |
| coef_a | input | 16 | Feedback coefficient a, Q1.15 |
| coef_b | input | 16 | Input coefficient b, Q1.15 |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample u, Q1.15 |
| out_valid | output | 1 | Output sample strobe, two cycles after in_valid |
| out_sample | output | 16 | Filtered output y, Q1.15 |

## Verification
The bench builds the block with the package defaults: 16-bit Q1.15 samples, Q2.30 derived coefficients and a 50-bit accumulator. Those widths let a = -1 and a·b = -1/2 be represented exactly. That choice makes the two-step form equal to the one-step direct recurrence, including the wrapping cases, so a hand-derived vector table applies. A zero feedback coefficient with b = 1/2 turns odd inputs into exact half-LSB ties, which exposes the rounding direction. Coefficient sets with inexact products are checked against an independent 64-bit evaluation of the two-step formula.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;

    // Sample word and derived widths.
    localparam int DW = 16;            // Q1.15 sample and coefficient width
    localparam int FW = DW - 1;        // fraction bits of a sample
    localparam int CW = 2 * DW;        // derived coefficient width, Q2.30
    localparam int PW = CW + DW;       // product of derived coefficient and sample
    localparam int AW = PW + 2;        // accumulator with growth guard
    localparam int RS = 2 * FW;        // shift from accumulator scale to samples

    typedef logic signed [DW-1:0] smp_t;
    typedef logic signed [CW-1:0] dcoef_t;
    typedef logic signed [AW-1:0] acc_t;

    function automatic acc_t widen_s(input smp_t x);
        return acc_t'(x);
    endfunction

    function automatic acc_t widen_c(input dcoef_t x);
        return acc_t'(x);
    endfunction

    function automatic dcoef_t cmul(input smp_t x, input smp_t y);
        return dcoef_t'(x) * dcoef_t'(y);
    endfunction

    // Round to nearest, ties up, then keep the low sample bits (wrap).
    function automatic smp_t round_wrap(input acc_t s);
        acc_t r;
        r = (s + (acc_t'(1) <<< (RS - 1))) >>> RS;
        return r[DW-1:0];
    endfunction

endpackage

// File: rtl/iir_la_coef.sv
module iir_la_coef
    import iir_la_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  smp_t   a_in,
    input  smp_t   b_in,
    output dcoef_t a2_o,
    output dcoef_t ab_o,
    output smp_t   b_o
);

    typedef struct packed {
        smp_t   pend_a;
        smp_t   pend_b;
        dcoef_t a2;
        dcoef_t ab;
        smp_t   b;
    } coef_st_t;

    coef_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.pend_a = a_in;
            st_d.pend_b = b_in;
        end
        // Active set is refreshed only while the filter state is being cleared.
        if (rst) begin
            st_d.a2 = cmul(st_q.pend_a, st_q.pend_a);
            st_d.ab = cmul(st_q.pend_a, st_q.pend_b);
            st_d.b  = st_q.pend_b;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign a2_o = st_q.a2;
    assign ab_o = st_q.ab;
    assign b_o  = st_q.b;

    // R7: outside reset the active coefficients never move.
    p_coef_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(a2_o) && $stable(ab_o) && $stable(b_o)));

endmodule

// File: rtl/iir_la_ffwd.sv
module iir_la_ffwd
    import iir_la_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  smp_t   in_sample,
    input  dcoef_t ab_coef,
    input  smp_t   b_coef,
    output acc_t   sum_o,
    output logic   sum_valid
);

    typedef struct packed {
        smp_t u_prev;
        acc_t sum;
        logic vld;
    } ff_st_t;

    ff_st_t st_d, st_q;

    // Feed-forward half: a*b*u(k-1) + b*u(k), aligned to the Q.45 accumulator scale.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.sum    = widen_c(ab_coef) * widen_s(st_q.u_prev)
                        + ((widen_s(b_coef) * widen_s(in_sample)) <<< FW);
            st_d.u_prev = in_sample;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sum_o     = st_q.sum;
    assign sum_valid = st_q.vld;

endmodule

// File: rtl/iir_la_loop.sv
module iir_la_loop
    import iir_la_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sum_valid,
    input  acc_t   sum_i,
    input  dcoef_t a2_coef,
    output smp_t   y_o,
    output logic   y_valid
);

    typedef struct packed {
        smp_t y_new;   // y(k)
        smp_t y_old;   // y(k-1)
        logic vld;
    } lp_st_t;

    lp_st_t st_d, st_q;
    acc_t   fb_sum;

    // Feedback half: two registers sit between y(k-1) and y(k+1).
    always_comb begin
        st_d     = st_q;
        st_d.vld = sum_valid;
        fb_sum   = widen_c(a2_coef) * widen_s(st_q.y_old) + sum_i;
        if (sum_valid) begin
            st_d.y_new = round_wrap(fb_sum);
            st_d.y_old = st_q.y_new;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_o     = st_q.y_new;
    assign y_valid = st_q.vld;

endmodule

// File: rtl/iir_la_top.sv
module iir_la_top
    import iir_la_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_wr,
    input  logic signed [DW-1:0] coef_a,
    input  logic signed [DW-1:0] coef_b,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);

    dcoef_t a2_w, ab_w;
    smp_t   b_w;
    acc_t   sum_w;
    logic   sum_vld_w;

    iir_la_coef u_coef (
        .clk  (clk),
        .rst  (rst),
        .wr   (coef_wr),
        .a_in (coef_a),
        .b_in (coef_b),
        .a2_o (a2_w),
        .ab_o (ab_w),
        .b_o  (b_w)
    );

    iir_la_ffwd u_ffwd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .ab_coef   (ab_w),
        .b_coef    (b_w),
        .sum_o     (sum_w),
        .sum_valid (sum_vld_w)
    );

    iir_la_loop u_loop (
        .clk       (clk),
        .rst       (rst),
        .sum_valid (sum_vld_w),
        .sum_i     (sum_w),
        .a2_coef   (a2_w),
        .y_o       (out_sample),
        .y_valid   (out_valid)
    );

    // R5: every accepted sample yields an output two cycles later.
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R5: no output without a sample two cycles earlier.
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R6: the output word holds between results.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_sample));

    // R5: the input strobe reaches the feedback stage exactly one cycle later.
    p_stage_align_r5: assert property (@(posedge clk) disable iff (rst)
        sum_vld_w |=> out_valid);

endmodule

// File: tb/sim_iir_la_top.sv
module sim_iir_la_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coef_wr = 1'b0;
    logic signed [15:0] coef_a = '0;
    logic signed [15:0] coef_b = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid;
    logic signed [15:0] out_sample;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    iir_la_top u0 (
        .clk        (clk),
        .rst        (rst),
        .coef_wr    (coef_wr),
        .coef_a     (coef_a),
        .coef_b     (coef_b),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // a = -1, b = 1/2, even inputs: direct recurrence y' = -y + u/2 (wrap), exact.
    localparam int NV = 12;
    localparam logic signed [15:0] VEC_U [NV] = '{
        16'sd1000, 16'sd2000, -16'sd4000, 16'sd0, 16'sd32766, -16'sd32768,
        16'sd32766, 16'sd32766, -16'sd32768, 16'sd2, -16'sd2, -16'sd6 };
    localparam logic signed [15:0] VEC_Y [NV] = '{
        16'sd500, 16'sd500, -16'sd2500, 16'sd2500, 16'sd13883, -16'sd30267,
        -16'sd18886, -16'sd30267, 16'sd13883, -16'sd13882, 16'sd13881, -16'sd13884 };

    logic signed [15:0] obuf [128];
    logic signed [15:0] ebuf [128];
    int ocnt = 0;
    int ecnt = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (ocnt < 128) obuf[ocnt] = out_sample;
            ocnt++;
        end
    end

    // Independent two-step model state.
    longint m_ym1, m_y0, m_up;
    logic [15:0] lf;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
        m_ym1 = 0; m_y0 = 0; m_up = 0;
        ocnt = 0; ecnt = 0;
    endtask

    task automatic load_coefs(input logic signed [15:0] a, input logic signed [15:0] b);
        @(negedge clk);
        in_valid = 1'b0;
        coef_a = a; coef_b = b; coef_wr = 1'b1;
        @(negedge clk);
        coef_wr = 1'b0;
        coef_a = 16'sh1234; coef_b = 16'sh4321;
    endtask

    task automatic send(input logic signed [15:0] u, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = u;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sample = 16'sh5A5A;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic signed [15:0] la_model(input longint a, input longint b,
            input longint ym1, input longint up, input longint u);
        longint acc;
        acc = a * a * ym1 + a * b * up + ((b * u) <<< 15);
        acc = (acc + (longint'(1) <<< 29)) >>> 30;
        return acc[15:0];
    endfunction

    task automatic stream(input logic signed [15:0] a, input logic signed [15:0] b,
            input int n, input int gap_every);
        logic signed [15:0] u, y;
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            u = lf;
            y = la_model(longint'(a), longint'(b), m_ym1, m_up, longint'(u));
            m_ym1 = m_y0; m_y0 = longint'(y); m_up = longint'(u);
            ebuf[ecnt] = y; ecnt++;
            send(u, (gap_every != 0 && (i % gap_every) == 0) ? 2 : 0);
        end
    endtask

    task automatic compare(input string req);
        idle(4);
        chk({req, " output count"}, ocnt, ecnt);
        for (int i = 0; i < ecnt && i < 128; i++) chk(req, obuf[i], ebuf[i]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic signed [15:0] held;
        lf = 16'hACE1;

        // R4: reset state, coefficients a = -1, b = 1/2.
        load_coefs(-16'sd32768, 16'sd16384);
        do_reset(3);
        chk("R4 out_valid after reset", int'(out_valid), 0);
        chk("R4 out_sample after reset", out_sample, 0);

        // R1 R8 R9: table walked back to back.
        for (int i = 0; i < NV; i++) send(VEC_U[i], 0);
        idle(4);
        chk("R8 table output count", ocnt, NV);
        for (int i = 0; i < NV; i++) chk("R1/R9 table", obuf[i], VEC_Y[i]);

        // R6: same table with idle gaps of 0..2 cycles.
        do_reset(2);
        for (int i = 0; i < NV; i++) send(VEC_U[i], i % 3);
        idle(4);
        chk("R6 gapped output count", ocnt, NV);
        for (int i = 0; i < NV; i++) chk("R6 gapped table", obuf[i], VEC_Y[i]);
        held = out_sample;
        idle(6);
        chk("R6 output holds while idle", out_sample, held);

        // R5: latency of exactly two cycles, one pulse per sample.
        do_reset(2);
        @(negedge clk); in_valid = 1'b1; in_sample = 16'sd2000;
        @(negedge clk); in_valid = 1'b0;
        chk("R5 no output after one cycle", int'(out_valid), 0);
        @(negedge clk);
        chk("R5 output after two cycles", int'(out_valid), 1);
        chk("R5 first output value", out_sample, 1000);
        @(negedge clk);
        chk("R5 single pulse", int'(out_valid), 0);

        // R3: rounding ties with a = 0, b = 1/2.
        load_coefs(16'sd0, 16'sd16384);
        do_reset(2);
        send(16'sd1, 0); send(-16'sd1, 0); send(16'sd3, 0); send(-16'sd3, 0);
        idle(4);
        chk("R3 round count", ocnt, 4);
        chk("R3 +0.5 LSB", obuf[0], 1);
        chk("R3 -0.5 LSB", obuf[1], 0);
        chk("R3 +1.5 LSB", obuf[2], 2);
        chk("R3 -1.5 LSB", obuf[3], -1);

        // R1 R2 R3: inexact coefficients against the two-step model.
        load_coefs(-16'sd29491, 16'sd9830);
        do_reset(2);
        stream(-16'sd29491, 16'sd9830, 40, 5);
        compare("R1/R2 a=-0.9 b=0.3");

        // R7: a write without reset leaves the active set alone.
        load_coefs(16'sd24576, 16'sd4096);
        do_reset(2);
        stream(16'sd24576, 16'sd4096, 20, 0);
        idle(1);
        load_coefs(-16'sd16384, 16'sd20000);
        stream(16'sd24576, 16'sd4096, 20, 0);
        compare("R7 write ignored until reset");

        // R7: reset activates the pending set.
        do_reset(2);
        stream(-16'sd16384, 16'sd20000, 30, 4);
        compare("R7 new set after reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule